// File: doc/BRIEF.md
# Column Current-Signature Mismatch Detector

This block is the digital compare stage behind a set of per-column current sensors on a small memory array. Each of the array's columns carries two sensor channels, one watching the column's supply rail and one watching its ground rail. Every channel delivers a pulse-width-modulated bit whose high time reflects the current drawn during an access. During each memory operation the block measures the high time of all channels and compares the columns against one another, rail by rail. A column whose signature stands apart from the bulk of its peers points to a resistive defect in one of its cells, even when no functional fault is visible. No expected data is needed, because the fault-free columns serve as the reference.

An operation window is open while the operation strobe is high and the array-select input marks this array as the active one. A change of operation code while the strobe stays high closes one window and opens the next. When a window closes, any deviant column raises a sticky flag, and the lowest deviant column index plus the rail it was seen on are captured and held until software-free clearing through the clear input.

Top module: `colsig_mismatch_det`

## Requirements
- R1: After reset the flag is 0, the reported column index is 0 and the reported rail bit is 0.
- R2: Each channel counts the clock cycles in which its sensor bit is 1 while both the operation strobe and the array select are 1; sensor activity outside such cycles adds nothing to any count.
- R3: At window close, a column is deviant on a rail when fewer than NUM_COLS/2+1 columns (itself included) have a count on that rail within the tolerance of its own; with 8 columns at least 5 must agree.
- R4: The supply and ground channels are judged separately; the rail bit reports 0 for the supply rail and 1 for the ground rail.
- R5: When several columns are deviant, the lowest index is reported; if that column is deviant on both rails the rail bit is 0.
- R6: The flag is sticky: once set it stays 1, and the captured column and rail hold, until the clear input is 1 at a clock edge with no new deviation being recorded in that same edge; a deviation at that edge wins and is captured.
- R7: While the array select is 0 no window opens, nothing is counted and the flag and captured values do not change.
- R8: A change of the operation code while the strobe stays high closes the running window (evaluating it) and restarts all counts for the next one.
- R9: A window closes in the first cycle where it is no longer open (or the code changed); the flag becomes 1 at the clock edge ending that cycle.
- R10: Counts saturate at 2**CNT_W-1 instead of wrapping.
- R11: Two counts that differ by exactly the tolerance agree; a difference of tolerance+1 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | High while a memory operation is in progress |
| opType | input | OP_W | Operation code; a change while opValid is high starts a new window |
| arraySel | input | 1 | High when this array owns the shared sensor set |
| sensVdd | input | NUM_COLS | PWM bit of each column's supply-rail sensor |
| sensGnd | input | NUM_COLS | PWM bit of each column's ground-rail sensor |
| tolerance | input | CNT_W | Largest count difference still treated as agreement |
| clearFlag | input | 1 | Clears the sticky flag |
| mismatchFlag | output | 1 | Sticky deviation flag |
| mismatchCol | output | COL_W | Lowest deviant column index captured |
| mismatchRail | output | 1 | Rail of the captured deviation (0 supply, 1 ground) |

## Verification
A single deviant duty cycle is injected on each of the sixteen column-rail channels in turn, which separates the column decode and the rail bit for every position. Tolerance is swept so that the deviant sits exactly at and one beyond the limit, telling an off-by-one in the distance test apart from a correct one. Multi-deviant patterns (two columns, both rails of one column, four-against-four and five-against-three splits) exercise the priority order and the quorum threshold, while gated, back-to-back and over-long windows show that counts ignore deselected activity, restart on an operation change and saturate rather than wrap.

// File: rtl/colsig_pkg.sv
package colsig_pkg;

  // Strobes from the window control to the datapath
  typedef struct packed {
    logic winStart;  // first cycle of a window: counters reload
    logic cntEn;     // window open: counters accumulate
    logic evalNow;   // window just closed: judge the counts
    logic flagClr;   // clear request for the sticky flag
  } sigStrobe_t;

  typedef enum logic {
    RAIL_SUPPLY = 1'b0,
    RAIL_GROUND = 1'b1
  } rail_e;

endpackage

// File: rtl/colsig_ctrl.sv
module colsig_ctrl
  import colsig_pkg::*;
#(
  parameter int OP_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opType,
  input  logic            arraySel,
  input  logic            clearReq,
  output sigStrobe_t      strobes
);

  logic            winOpen;
  logic            prevOpen;
  logic [OP_W-1:0] prevType;
  logic            typeChg;

  assign winOpen = opValid & arraySel;
  assign typeChg = (opType != prevType);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOpen <= 1'b0;
      prevType <= '0;
    end else begin
      prevOpen <= winOpen;
      prevType <= opType;
    end
  end

  always_comb begin
    strobes.winStart = winOpen & (~prevOpen | typeChg);
    strobes.cntEn    = winOpen;
    strobes.evalNow  = prevOpen & (~winOpen | typeChg);
    strobes.flagClr  = clearReq;
  end

endmodule

// File: rtl/colsig_counter.sv
module colsig_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sensBit,
  input  logic             winStart,
  input  logic             cntEn,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (winStart) begin
      count <= {{(CNT_W-1){1'b0}}, sensBit};
    end else if (cntEn && sensBit && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/colsig_agree.sv
module colsig_agree #(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 6
) (
  input  logic [NUM_COLS-1:0][CNT_W-1:0] counts,
  input  logic [CNT_W-1:0]               tol,
  output logic [NUM_COLS-1:0]            deviant
);

  localparam int              AGR_W  = $clog2(NUM_COLS + 1);
  localparam logic [AGR_W-1:0] QUORUM = AGR_W'(NUM_COLS / 2 + 1);

  logic [NUM_COLS-1:0][NUM_COLS-1:0] near;
  logic [NUM_COLS-1:0][AGR_W-1:0]    tally;

  for (genvar gi = 0; gi < NUM_COLS; gi++) begin : g_row
    for (genvar gj = 0; gj < NUM_COLS; gj++) begin : g_col
      logic [CNT_W-1:0] gap;
      assign gap = (counts[gi] > counts[gj]) ? (counts[gi] - counts[gj])
                                             : (counts[gj] - counts[gi]);
      assign near[gi][gj] = (gap <= tol);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_COLS; i++) begin
      tally[i] = '0;
      for (int j = 0; j < NUM_COLS; j++) begin
        tally[i] = tally[i] + AGR_W'(near[i][j]);
      end
      deviant[i] = (tally[i] < QUORUM);
    end
  end

endmodule

// File: rtl/colsig_datapath.sv
module colsig_datapath
  import colsig_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 6,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  sigStrobe_t          strobes,
  input  logic [NUM_COLS-1:0] sensVdd,
  input  logic [NUM_COLS-1:0] sensGnd,
  input  logic [CNT_W-1:0]    tolerance,
  output logic                flag,
  output logic [COL_W-1:0]    flagCol,
  output rail_e               flagRail
);

  localparam int NUM_RAILS = 2;

  logic [NUM_RAILS-1:0][NUM_COLS-1:0]            sensRail;
  logic [NUM_RAILS-1:0][NUM_COLS-1:0][CNT_W-1:0] railCnt;
  logic [NUM_RAILS-1:0][NUM_COLS-1:0]            railDev;

  assign sensRail[RAIL_SUPPLY] = sensVdd;
  assign sensRail[RAIL_GROUND] = sensGnd;

  for (genvar gr = 0; gr < NUM_RAILS; gr++) begin : g_rail
    for (genvar gc = 0; gc < NUM_COLS; gc++) begin : g_chan
      colsig_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rstN     (rstN),
        .sensBit  (sensRail[gr][gc]),
        .winStart (strobes.winStart),
        .cntEn    (strobes.cntEn),
        .count    (railCnt[gr][gc])
      );
    end

    colsig_agree #(.NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) u_agree (
      .counts  (railCnt[gr]),
      .tol     (tolerance),
      .deviant (railDev[gr])
    );
  end

  // Lowest column wins; supply rail wins inside a column
  logic             hit;
  logic [COL_W-1:0] hitCol;
  rail_e            hitRail;

  always_comb begin
    hit     = 1'b0;
    hitCol  = '0;
    hitRail = RAIL_SUPPLY;
    for (int i = NUM_COLS - 1; i >= 0; i--) begin
      if (railDev[RAIL_SUPPLY][i] || railDev[RAIL_GROUND][i]) begin
        hit     = 1'b1;
        hitCol  = COL_W'(i);
        hitRail = railDev[RAIL_SUPPLY][i] ? RAIL_SUPPLY : RAIL_GROUND;
      end
    end
  end

  logic record;
  assign record = strobes.evalNow & hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag     <= 1'b0;
      flagCol  <= '0;
      flagRail <= RAIL_SUPPLY;
    end else if (record) begin
      flag <= 1'b1;
      if (!flag || strobes.flagClr) begin
        flagCol  <= hitCol;
        flagRail <= hitRail;
      end
    end else if (strobes.flagClr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/colsig_mismatch_det.sv
module colsig_mismatch_det
  import colsig_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 6,
  parameter int OP_W     = 2,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [OP_W-1:0]     opType,
  input  logic                arraySel,
  input  logic [NUM_COLS-1:0] sensVdd,
  input  logic [NUM_COLS-1:0] sensGnd,
  input  logic [CNT_W-1:0]    tolerance,
  input  logic                clearFlag,
  output logic                mismatchFlag,
  output logic [COL_W-1:0]    mismatchCol,
  output logic                mismatchRail
);

  sigStrobe_t strobes;
  rail_e      railSel;

  colsig_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opType   (opType),
    .arraySel (arraySel),
    .clearReq (clearFlag),
    .strobes  (strobes)
  );

  colsig_datapath #(.NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sensVdd   (sensVdd),
    .sensGnd   (sensGnd),
    .tolerance (tolerance),
    .flag      (mismatchFlag),
    .flagCol   (mismatchCol),
    .flagRail  (railSel)
  );

  assign mismatchRail = railSel;

endmodule

// File: rtl/colsig_mismatch_chk.sv
module colsig_mismatch_chk #(
  parameter int COL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             arraySel,
  input logic             clearFlag,
  input logic             mismatchFlag,
  input logic [COL_W-1:0] mismatchCol,
  input logic             mismatchRail
);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchFlag && !clearFlag) |=> mismatchFlag);

  // R6
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchFlag && !clearFlag) |=> ($stable(mismatchCol) && $stable(mismatchRail)));

  // R6
  fall_by_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mismatchFlag) |-> $past(clearFlag));

  // R9
  rise_after_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mismatchFlag) |-> $past(opValid && arraySel, 2));

endmodule

bind colsig_mismatch_det colsig_mismatch_chk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .arraySel     (arraySel),
  .clearFlag    (clearFlag),
  .mismatchFlag (mismatchFlag),
  .mismatchCol  (mismatchCol),
  .mismatchRail (mismatchRail)
);

// File: tb/tb_colsig_mismatch_det.sv
module tb_colsig_mismatch_det;

  localparam int NC    = 8;
  localparam int CW    = 6;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic [1:0]    opType = 2'd0;
  logic          arraySel = 1'b1;
  logic [NC-1:0] sensVdd = '0;
  logic [NC-1:0] sensGnd = '0;
  logic [CW-1:0] tolerance = '0;
  logic          clearFlag = 1'b0;
  logic          mismatchFlag;
  logic [2:0]    mismatchCol;
  logic          mismatchRail;

  always #10 clk = ~clk;

  colsig_mismatch_det #(.NUM_COLS(NC), .CNT_W(CW), .OP_W(2)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opType(opType),
    .arraySel(arraySel), .sensVdd(sensVdd), .sensGnd(sensGnd),
    .tolerance(tolerance), .clearFlag(clearFlag),
    .mismatchFlag(mismatchFlag), .mismatchCol(mismatchCol),
    .mismatchRail(mismatchRail)
  );

  int nTests = 0;
  int nFail  = 0;
  int hiV[NC];
  int hiG[NC];
  bit expFlag;
  int expCol;
  int expRail;

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int satCnt(input int h, input int len);
    int c;
    c = (h < len) ? h : len;
    return (c > CMAX) ? CMAX : c;
  endfunction

  // Reference judgement from the requirements (R3, R5, R10, R11)
  task automatic predict(input int len, input int tol);
    int cnt[2][NC];
    bit dev[2][NC];
    for (int c = 0; c < NC; c++) begin
      cnt[0][c] = satCnt(hiV[c], len);
      cnt[1][c] = satCnt(hiG[c], len);
    end
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < NC; i++) begin
        int agree = 0;
        for (int j = 0; j < NC; j++) begin
          int d = cnt[r][i] - cnt[r][j];
          if (d < 0) d = -d;
          if (d <= tol) agree++;
        end
        dev[r][i] = (agree < NC / 2 + 1);
      end
    expFlag = 0; expCol = 0; expRail = 0;
    for (int i = NC - 1; i >= 0; i--)
      if (dev[0][i] || dev[1][i]) begin
        expFlag = 1; expCol = i; expRail = dev[0][i] ? 0 : 1;
      end
  endtask

  task automatic setAll(input int v, input int g);
    for (int c = 0; c < NC; c++) begin hiV[c] = v; hiG[c] = g; end
  endtask

  task automatic window(input int len, input logic [1:0] ty, input logic sel, input bit drop);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      opValid = 1'b1; arraySel = sel; opType = ty;
      for (int c = 0; c < NC; c++) begin
        sensVdd[c] = (t < hiV[c]);
        sensGnd[c] = (t < hiG[c]);
      end
    end
    if (drop) begin
      @(negedge clk);
      opValid = 1'b0; sensVdd = '0; sensGnd = '0;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clearIt();
    @(negedge clk); clearFlag = 1'b1;
    @(negedge clk); clearFlag = 1'b0;
  endtask

  task automatic runCase(input string req, input int len, input int tol);
    tolerance = CW'(tol);
    window(len, 2'd1, 1'b1, 1);
    settle();
    predict(len, tol);
    chk(req, mismatchFlag, expFlag);
    if (expFlag) begin
      chk(req, mismatchCol, expCol);
      chk(req, mismatchRail, expRail);
    end
    clearIt();
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", mismatchFlag, 0);
    chk("R1", mismatchCol, 0);
    chk("R1", mismatchRail, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R4: single deviant on every column and rail
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < NC; c++) begin
        setAll(10, 10);
        if (r == 0) hiV[c] = 16; else hiG[c] = 16;
        runCase("R3_R4", 20, 2);
      end

    // R11 tolerance boundary
    for (int tol = 0; tol < 4; tol++) begin
      setAll(8, 8); hiV[5] = 8 + tol;
      runCase("R11_at", 20, tol);
      setAll(8, 8); hiV[5] = 8 + tol + 1;
      runCase("R11_over", 20, tol);
    end

    // R5 priority
    setAll(6, 6); hiG[6] = 14; hiG[2] = 1;
    runCase("R5_two", 20, 1);
    setAll(6, 6); hiG[3] = 14; hiV[3] = 14;
    runCase("R5_both", 20, 1);

    // R3 quorum: four against four, five against three
    setAll(4, 4); for (int c = 4; c < NC; c++) hiV[c] = 12;
    runCase("R3_split44", 20, 0);
    setAll(4, 4); hiG[1] = 12; hiG[4] = 12; hiG[7] = 12;
    runCase("R3_split53", 20, 0);

    // R7 deselected array: no evaluation
    setAll(10, 10); hiV[0] = 0;
    tolerance = 0;
    window(20, 2'd1, 1'b0, 1);
    settle();
    chk("R7", mismatchFlag, 0);
    arraySel = 1'b1;

    // R2 activity outside a window is not counted
    for (int t = 0; t < 30; t++) begin
      @(negedge clk); opValid = 1'b0; sensVdd = 8'h01; sensGnd = 8'h80;
    end
    @(negedge clk); sensVdd = '0; sensGnd = '0;
    setAll(10, 10);
    window(20, 2'd1, 1'b1, 1);
    settle();
    chk("R2", mismatchFlag, 0);

    // R9 timing and R6 stickiness
    setAll(9, 9); hiG[4] = 0;
    tolerance = 1;
    window(20, 2'd1, 1'b1, 0);
    @(negedge clk); opValid = 1'b0; sensVdd = '0; sensGnd = '0;
    chk("R9_before", mismatchFlag, 0);
    @(negedge clk);
    chk("R9_after", mismatchFlag, 1);
    chk("R9_col", mismatchCol, 4);
    setAll(9, 9); hiV[1] = 0;
    window(20, 2'd1, 1'b1, 1);
    settle();
    chk("R6_flag", mismatchFlag, 1);
    chk("R6_col", mismatchCol, 4);
    chk("R6_rail", mismatchRail, 1);
    clearIt();
    chk("R6_clear", mismatchFlag, 0);

    // R8 code change restarts counts: each window alone agrees
    setAll(0, 0); hiV[3] = 10;
    tolerance = 15;
    window(10, 2'd0, 1'b1, 0);
    window(10, 2'd1, 1'b1, 1);
    settle();
    chk("R8_restart", mismatchFlag, 0);
    // R8 code change evaluates the closing window
    setAll(10, 10); hiV[6] = 0;
    tolerance = 2;
    window(10, 2'd2, 1'b1, 0);
    setAll(10, 10);
    window(10, 2'd3, 1'b1, 0);
    chk("R8_eval", mismatchFlag, 1);
    chk("R8_col", mismatchCol, 6);
    @(negedge clk); opValid = 1'b0; sensVdd = '0; sensGnd = '0;
    settle();
    clearIt();

    // R10 saturation: 80 versus 70 both clip to the maximum
    setAll(80, 80); hiV[2] = 70;
    runCase("R10", 80, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule